// File: doc/BRIEF.md
# Tagged HDLC Receive Byte FIFO

This block sits between an HDLC receive deframer and the host's register interface. The deframer hands it one byte at a time. Each byte comes with a two-bit packet-status tag, and the block stores the tag with the byte. The host sees the oldest entry at a read head and removes it with a one-cycle pop strobe. Occupancy, empty and full outputs let the host pace its reads.

Entry to the FIFO is decided per packet. A packet is taken only if it starts with a beginning-of-packet byte while the receiver is enabled and there is room. Bytes that arrive when no packet is open are discarded. A packet whose bytes no longer fit is truncated. The truncated bytes are dropped, stored entries are never overwritten, and the block ignores traffic until the next beginning-of-packet byte.

Two sticky interrupt flags report packet ends. One is set when a last-of-packet byte enters the FIFO. The other is set when a last-of-packet byte reaches the read head, so the host can look at its good or bad tag before popping it.

Top module: `hrf_rx_tag_fifo`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, and both interrupt flags are 0.
- R2: Tag codes are 00 for a middle byte, 01 for beginning of packet, 10 for last byte good and 11 for last byte bad. Accepted bytes come out in write order with their tags. rd_data and rd_tag show the oldest entry, and a pop removes it. The depth is 16 by default.
- R3: If a byte of an open packet arrives while the FIFO is full and no pop happens in that cycle, the byte is dropped. Count and the head entry stay the same. Every later byte of that packet is also dropped, even after space frees up, until a new 01-tagged byte arrives.
- R4: A 01-tagged byte that arrives with the receiver enabled and space available opens a new packet. This holds after an overflow, once the FIFO has drained.
- R5: After a truncated packet, the popped tag stream holds two 01 tags with no 10 or 11 tag between them.
- R6: irq_eopd goes to 1 in the cycle after an accepted byte tagged 10 or 11 is written. It stays set until irq_clr[0] is pulsed. A set in the same cycle wins over the clear.
- R7: irq_eopr goes to 1 one cycle after a 10- or 11-tagged entry becomes the head of a non-empty FIFO. It stays set until irq_clr[1] is pulsed.
- R8: A packet whose 01 byte arrives while rx_en is 0 is ignored entirely. Enabling the receiver in the middle of a packet does not admit the rest of that packet.
- R9: Dropping rx_en while a packet is open lets that packet finish. Packets that start later are refused.
- R10: While rx_en is 0, pops, the head outputs, count and the interrupt flags keep working.
- R11: On a full FIFO, a pop and a write in the same cycle both take effect, and count stays at 16.
- R12: A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable, sampled at packet start |
| wr_valid | input | 1 | Byte strobe from the deframer |
| wr_data | input | 8 | Received byte |
| wr_tag | input | 2 | Status tag of the received byte |
| rd_pop | input | 1 | Host removes the head entry |
| rd_data | output | 8 | Head entry data (invalid when empty) |
| rd_tag | output | 2 | Head entry tag (invalid when empty) |
| empty | output | 1 | No entries stored |
| full | output | 1 | All entries used |
| count | output | 5 | Number of stored entries |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 end-written flag, bit 1 end-at-head flag |
| irq_eopd | output | 1 | Sticky flag: an end-of-packet byte was written |
| irq_eopr | output | 1 | Sticky flag: an end-of-packet byte is at the head |

## Verification
A vector table first streams short packets with interleaved pops. It compares count and head tag/data after every cycle, which separates correct ordering and same-cycle push/pop from lost or duplicated entries. Directed patterns then fill the FIFO with one long packet, do a simultaneous push and pop at full, and offer overflow bytes, an end byte and a stray middle byte. These patterns separate truncation that is dropped from overwriting, and a clean restart after the drain from a lingering drop state. They also check the double-beginning signature in the popped tag stream. Toggling rx_en before, during and after packets separates packet-level admission from byte-level gating.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
    typedef enum logic [1:0] {
        TAG_MID     = 2'b00,
        TAG_BOP     = 2'b01,
        TAG_EOP_OK  = 2'b10,
        TAG_EOP_BAD = 2'b11
    } tag_e;

    function automatic logic tag_is_end(input logic [1:0] t);
        return t[1];
    endfunction
endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                cell_q[i] <= wdata;
            end
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/hrf_admit.sv
module hrf_admit
    import hrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       wr_valid,
    input  logic [1:0] wr_tag,
    input  logic       room,
    output logic       accept
);
    typedef struct packed {
        logic open;
    } adm_t;

    adm_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        if (wr_valid) begin
            if (wr_tag == TAG_BOP) begin
                accept    = rx_en && room;
                st_d.open = rx_en && room;
            end else if (st_q.open) begin
                if (room) begin
                    accept    = 1'b1;
                    st_d.open = !tag_is_end(wr_tag);
                end else begin
                    st_d.open = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hrf_irq.sv
module hrf_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       end_written,
    input  logic       end_at_head,
    input  logic [1:0] clr,
    output logic       eopd,
    output logic       eopr
);
    typedef struct packed {
        logic eopd;
        logic eopr;
        logic head_prev;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d.eopd      = end_written | (st_q.eopd & ~clr[0]);
        st_d.eopr      = (end_at_head & ~st_q.head_prev) | (st_q.eopr & ~clr[1]);
        st_d.head_prev = end_at_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eopd = st_q.eopd;
    assign eopr = st_q.eopr;
endmodule

// File: rtl/hrf_rx_tag_fifo.sv
module hrf_rx_tag_fifo
    import hrf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int EW    = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_tag,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_tag,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     count,
    input  logic [1:0]        irq_clr,
    output logic              irq_eopd,
    output logic              irq_eopr
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic do_pop, do_push, room;
    logic [EW-1:0] head;

    assign empty  = (st_q.cnt == '0);
    assign full   = (st_q.cnt == CW'(DEPTH));
    assign count  = st_q.cnt;
    assign do_pop = rd_pop && !empty;
    assign room   = !full || do_pop;

    hrf_admit u_admit (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .wr_valid (wr_valid),
        .wr_tag   (wr_tag),
        .room     (room),
        .accept   (do_push)
    );

    hrf_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .clk   (clk),
        .we    (do_push),
        .waddr (st_q.wptr),
        .wdata ({wr_data, wr_tag}),
        .raddr (st_q.rptr),
        .rdata (head)
    );

    assign rd_data = head[EW-1:2];
    assign rd_tag  = head[1:0];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wptr = st_q.wptr + AW'(1);
        if (do_pop)  st_d.rptr = st_q.rptr + AW'(1);
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hrf_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .end_written (do_push && tag_is_end(wr_tag)),
        .end_at_head (!empty && tag_is_end(rd_tag)),
        .clr         (irq_clr),
        .eopd        (irq_eopd),
        .eopr        (irq_eopr)
    );
endmodule

// File: rtl/hrf_chk.sv
module hrf_chk #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [1:0]        wr_tag,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        rd_tag,
    input logic              empty,
    input logic              full,
    input logic [CW-1:0]     count,
    input logic              irq_eopd,
    input logic              irq_eopr
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_head_kept_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_pop) |=> ($stable(rd_data) && $stable(rd_tag) && $stable(count)));

    assert_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_valid) |=> empty);

    assert_eopd_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_eopd) |-> ($past(wr_valid) && $past(wr_tag[1])));

    assert_eopr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_eopr) |-> ($past(!empty) && $past(rd_tag[1])));
endmodule

bind hrf_rx_tag_fifo hrf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_tag   (wr_tag),
    .rd_pop   (rd_pop),
    .rd_data  (rd_data),
    .rd_tag   (rd_tag),
    .empty    (empty),
    .full     (full),
    .count    (count),
    .irq_eopd (irq_eopd),
    .irq_eopr (irq_eopr)
);

// File: tb/tb_hrf_rx_tag_fifo.sv
module tb_hrf_rx_tag_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_tag = '0;
    logic       rd_pop = 1'b0;
    logic [1:0] irq_clr = '0;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;
    logic       empty, full, irq_eopd, irq_eopr;
    logic [4:0] count;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] got_d;
    logic [1:0] got_t;

    always #2.5 clk = ~clk;

    hrf_rx_tag_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_tag(wr_tag), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_tag(rd_tag), .empty(empty), .full(full),
        .count(count), .irq_clr(irq_clr), .irq_eopd(irq_eopd), .irq_eopr(irq_eopr)
    );

    // {wv, tag, data, pop, exp_count, exp_head_data, exp_head_tag}
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 2'b01, 8'hA1, 1'b0, 5'd1, 8'hA1, 2'b01},
        {1'b1, 2'b00, 8'h22, 1'b0, 5'd2, 8'hA1, 2'b01},
        {1'b1, 2'b10, 8'h33, 1'b1, 5'd2, 8'h22, 2'b00},
        {1'b0, 2'b00, 8'h00, 1'b1, 5'd1, 8'h33, 2'b10},
        {1'b1, 2'b01, 8'h44, 1'b1, 5'd1, 8'h44, 2'b01},
        {1'b1, 2'b00, 8'h55, 1'b0, 5'd2, 8'h44, 2'b01},
        {1'b1, 2'b11, 8'h66, 1'b0, 5'd3, 8'h44, 2'b01},
        {1'b0, 2'b00, 8'h00, 1'b1, 5'd2, 8'h55, 2'b00},
        {1'b0, 2'b00, 8'h00, 1'b1, 5'd1, 8'h66, 2'b11},
        {1'b0, 2'b00, 8'h00, 1'b1, 5'd0, 8'h00, 2'b00},
        {1'b1, 2'b00, 8'h77, 1'b0, 5'd0, 8'h00, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: head captured before the edge, results sampled 1 ns after it
    task automatic cyc(input logic wv, input logic [1:0] t, input logic [7:0] d,
                       input logic p, input logic [1:0] c);
        @(negedge clk);
        got_d = rd_data; got_t = rd_tag;
        wr_valid = wv; wr_tag = t; wr_data = d; rd_pop = p; irq_clr = c;
        @(posedge clk);
        #1;
        wr_valid = 1'b0; rd_pop = 1'b0; irq_clr = 2'b00;
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic bop_open, dbl_bop;
        int bad;
        #12 rst_n = 1'b1;
        #1;
        chk("R1 count", 32'(count), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 irqs", 32'({irq_eopd, irq_eopr}), 0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][26], VEC[i][25:24], VEC[i][23:16], VEC[i][15], 2'b00);
            chk($sformatf("R2 vec%0d count", i), 32'(count), 32'(VEC[i][14:10]));
            if (VEC[i][14:10] != 0) begin
                chk($sformatf("R2 vec%0d head", i), 32'({rd_data, rd_tag}), 32'(VEC[i][9:0]));
            end
        end
        chk("R8 stray middle byte ignored, empty", 32'(empty), 1);
        chk("R6 eopd set", 32'(irq_eopd), 1);
        chk("R7 eopr set", 32'(irq_eopr), 1);
        cyc(1'b0, 2'b00, 8'h00, 1'b0, 2'b11);
        chk("R6 R7 cleared", 32'({irq_eopd, irq_eopr}), 0);

        // fill with one open packet, then push+pop at full, then overflow
        cyc(1'b1, 2'b01, 8'h00, 1'b0, 2'b00);
        for (int i = 1; i < 16; i++) cyc(1'b1, 2'b00, 8'(i), 1'b0, 2'b00);
        chk("R2 full at 16", 32'({full, count}), 32'({1'b1, 5'd16}));
        cyc(1'b1, 2'b00, 8'h5A, 1'b1, 2'b00);
        chk("R11 count stays 16", 32'(count), 16);
        chk("R11 popped BOP", 32'({got_d, got_t}), 32'({8'h00, 2'b01}));
        bop_open = 1'b1; dbl_bop = 1'b0;
        cyc(1'b1, 2'b00, 8'hEE, 1'b0, 2'b00);
        chk("R3 count held", 32'(count), 16);
        chk("R3 head kept", 32'({rd_data, rd_tag}), 32'({8'h01, 2'b00}));
        cyc(1'b1, 2'b10, 8'hEF, 1'b0, 2'b00);
        chk("R3 end byte dropped, no eopd", 32'(irq_eopd), 0);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b00);
            if (got_d != ((i < 15) ? 8'(i + 1) : 8'h5A)) bad++;
            if (got_t == 2'b01) begin
                if (bop_open) dbl_bop = 1'b1;
                bop_open = 1'b1;
            end else if (got_t[1]) bop_open = 1'b0;
        end
        chk("R3 drained order intact", 32'(bad), 0);
        cyc(1'b1, 2'b00, 8'h77, 1'b0, 2'b00);
        chk("R3 drop state persists after drain", 32'(count), 0);
        cyc(1'b1, 2'b01, 8'h90, 1'b0, 2'b00);
        cyc(1'b1, 2'b10, 8'h91, 1'b0, 2'b00);
        chk("R4 next packet accepted", 32'(count), 2);
        chk("R6 eopd after accepted end", 32'(irq_eopd), 1);
        for (int i = 0; i < 2; i++) begin
            cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b00);
            if (got_t == 2'b01) begin
                if (bop_open) dbl_bop = 1'b1;
                bop_open = 1'b1;
            end else if (got_t[1]) bop_open = 1'b0;
        end
        chk("R5 double BOP seen", 32'(dbl_bop), 1);
        chk("R5 last popped tag good end", 32'(got_t), 32'(2'b10));

        // set wins over same-cycle clear
        cyc(1'b0, 2'b00, 8'h00, 1'b0, 2'b11);
        cyc(1'b1, 2'b01, 8'hB0, 1'b0, 2'b00);
        cyc(1'b1, 2'b11, 8'hB1, 1'b0, 2'b01);
        chk("R6 set beats clear", 32'(irq_eopd), 1);
        cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b00);
        cyc(1'b0, 2'b00, 8'h00, 1'b0, 2'b00);
        chk("R7 eopr on bad end at head", 32'({irq_eopr, rd_tag}), 32'({1'b1, 2'b11}));
        cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b11);
        chk("R12 setup empty", 32'(empty), 1);
        cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b00);
        chk("R12 pop on empty", 32'({empty, count}), 32'({1'b1, 5'd0}));

        // enable handling
        rx_en = 1'b0;
        cyc(1'b1, 2'b01, 8'hC0, 1'b0, 2'b00);
        cyc(1'b1, 2'b00, 8'hC1, 1'b0, 2'b00);
        rx_en = 1'b1;
        cyc(1'b1, 2'b00, 8'hC2, 1'b0, 2'b00);
        cyc(1'b1, 2'b10, 8'hC3, 1'b0, 2'b00);
        chk("R8 packet refused", 32'({count, irq_eopd}), 32'({5'd0, 1'b0}));
        cyc(1'b1, 2'b01, 8'hD0, 1'b0, 2'b00);
        rx_en = 1'b0;
        cyc(1'b1, 2'b00, 8'hD1, 1'b0, 2'b00);
        cyc(1'b1, 2'b10, 8'hD2, 1'b0, 2'b00);
        chk("R9 open packet completes", 32'(count), 3);
        cyc(1'b1, 2'b01, 8'hE0, 1'b0, 2'b00);
        cyc(1'b1, 2'b10, 8'hE1, 1'b0, 2'b00);
        chk("R9 new packet refused", 32'(count), 3);
        chk("R10 eopd readable", 32'(irq_eopd), 1);
        cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b00);
        chk("R10 pop while disabled", 32'({got_d, count}), 32'({8'hD0, 5'd2}));
        cyc(1'b0, 2'b00, 8'h00, 1'b1, 2'b00);
        cyc(1'b0, 2'b00, 8'h00, 1'b0, 2'b00);
        chk("R10 head end and eopr while disabled",
            32'({rd_data, rd_tag, irq_eopr}), 32'({8'hD2, 2'b10, 1'b1}));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule